// File: doc/BRIEF.md
# Packet Writeback Commit Queue

This block collects the register writes and program-counter writes that the instructions of one issue packet produce, and holds them back until the packet ends. When the commit is started, the entries are walked in the order they arrived, one per cycle. Data writes are sent out on a write port toward the register file. PC writes are not sent out; they choose the address of the next packet instead.

The commit is filtered. Only the first surviving branch takes effect. If an imprecise exception is pending, entries issued by the faulting instruction may be dropped. Whether they are dropped depends on the exception class, its status bits and a force flag carried by each entry. A pending link request adds one final write of the packet PC to the link register. The queue is cleared after every commit, and also when a new packet opens.

Entries arrive over a valid/ready interface. `enq_ready` is high only while the block is idle, the queue is not full, and neither `pkt_start` nor `commit_start` is asserted. An entry is taken on a cycle where `enq_valid` and `enq_ready` are both high. A producer that holds `enq_valid` high while the idle queue is full loses that entry, and `overflow_err` is raised in that cycle. The write port uses valid/ready as well. Once `wr_valid` is high it stays high, with dest and value stable, until `wr_ready` is sampled high. While it waits, the walk through the queue stalls.

Top module: `pcq_top`

## Requirements
- R1: Data-write entries (kind 0) that survive filtering appear on the write port in the order they were enqueued, each with its own dest and value.
- R2: Among the surviving PC-write entries (kind 1), only the first one sets `next_pc`, taking its value. Later ones in the same packet have no effect. An entry removed by the exception filter does not count as the first.
- R3: If no PC-write entry survives, `next_pc` equals the `cur_pc` value sampled with `commit_start`.
- R4: While an exception is pending, an entry whose issuing address differs from `exc_iaddr` always commits.
- R5: If the pending exception is a floating-point one (`exc_fp`=1), a matching entry commits only when `exc_status` has no bit set outside bits 0..2 (inexact, underflow, overflow). Otherwise it is dropped.
- R6: If the pending exception is of any other class, a matching entry commits only if its force flag is set.
- R7: While a data write is presented on the write port, `vis_pc` equals the issuing address of that entry.
- R8: After `link_set`, the next commit ends with one extra write to dest `LINK_DEST` (default 31) carrying the sampled `cur_pc`, and the link request is then cleared.
- R9: The queue is empty after each commit and after `pkt_start`. A commit that follows either one produces no data write.
- R10: With `DEPTH` (default 8) entries held, `enq_ready` is low and a valid enqueue raises `overflow_err` and is dropped.
- R11: `commit_done` and `next_pc_valid` rise together for exactly one cycle. With `wr_ready` held high this happens N+L+1 cycles after the edge that samples `commit_start`, where N is the number of stored entries and L is 1 if a link write is made.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_dest` and `wr_value` hold unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | New packet opens; clears the queue when idle |
| cur_pc | input | AW | Packet PC, sampled with commit_start |
| commit_start | input | 1 | Begins the commit walk (idle only) |
| link_set | input | 1 | Requests a link register write at the next commit |
| exc_pending | input | 1 | An imprecise exception is pending |
| exc_fp | input | 1 | The pending exception is floating-point |
| exc_status | input | SW | Exception status bits; bits 0..2 are the benign ones |
| exc_iaddr | input | AW | Address of the faulting instruction |
| enq_valid | input | 1 | Entry offered |
| enq_ready | output | 1 | Entry can be taken |
| enq_kind | input | 1 | 0 = data write, 1 = PC write |
| enq_value | input | DW | Value to write |
| enq_dest | input | RW | Destination register |
| enq_iaddr | input | AW | Issuing instruction address |
| enq_force | input | 1 | Commit even under a non-floating-point exception |
| overflow_err | output | 1 | Entry dropped because the queue was full |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Register file accepts the write |
| wr_dest | output | RW | Write destination |
| wr_value | output | DW | Write value |
| vis_pc | output | AW | Visible PC (issuing address during the walk) |
| next_pc | output | AW | Address of the next packet |
| next_pc_valid | output | 1 | next_pc is valid (one-cycle pulse) |
| commit_done | output | 1 | Commit finished (one-cycle pulse) |
| busy | output | 1 | A commit is in progress |

## Verification
The bench targets the branch filter with two PC writes, where the first comes from the faulting instruction and lacks the force flag. A design that counts a dropped branch as taken would report the wrong next address. It contrasts floating-point status with only benign bits against status with an invalid bit set, and tests forced against unforced entries under other exception classes. A design that applied the filter to every entry, or mixed up the two rules, would show extra or missing writes. It fills the queue past its depth, checks that a packet start really empties it, and checks that the link request fires once and does not persist. It also applies back-pressure on the write port, to catch an engine that advances or changes data while a write is still waiting.

// File: rtl/pcq_pkg.sv
package pcq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DRAIN = 2'd1,
    S_LINK  = 2'd2,
    S_FIN   = 2'd3
  } cq_state_e;

  // entry kinds
  localparam logic KIND_DATA = 1'b0;
  localparam logic KIND_PC   = 1'b1;

  // benign floating-point status bits: inexact, underflow, overflow
  localparam int BENIGN_BITS = 3;

endpackage

// File: rtl/pcq_store.sv
module pcq_store #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 72,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [ENT_W-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             full
);

  logic [ENT_W-1:0] mem [DEPTH];

  assign full    = (count == CW'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) begin
      mem[count[IW-1:0]] <= push_data;
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/pcq_filter.sv
module pcq_filter #(
  parameter int AW = 32,
  parameter int SW = 6
) (
  input  logic          kind,
  input  logic          force_wr,
  input  logic [AW-1:0] iaddr,
  input  logic          exc_pending,
  input  logic          exc_fp,
  input  logic [SW-1:0] exc_status,
  input  logic [AW-1:0] exc_iaddr,
  input  logic          branch_seen,
  output logic          keep,
  output logic          take_branch,
  output logic          emit_data
);
  import pcq_pkg::*;

  localparam logic [SW-1:0] BENIGN_MASK = SW'((1 << BENIGN_BITS) - 1);

  logic match;
  logic fp_ok;

  always_comb begin
    match = exc_pending && (iaddr == exc_iaddr);
    fp_ok = ((exc_status & ~BENIGN_MASK) == '0);
    if (!match) begin
      keep = 1'b1;
    end else if (exc_fp) begin
      keep = fp_ok;
    end else begin
      keep = force_wr;
    end
    take_branch = keep && (kind == KIND_PC) && !branch_seen;
    emit_data   = keep && (kind == KIND_DATA);
  end

endmodule

// File: rtl/pcq_top.sv
module pcq_top #(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int RW = 5,
  parameter int SW = 6,
  parameter logic [RW-1:0] LINK_DEST = 5'd31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic [AW-1:0] cur_pc,
  input  logic          commit_start,
  input  logic          link_set,
  input  logic          exc_pending,
  input  logic          exc_fp,
  input  logic [SW-1:0] exc_status,
  input  logic [AW-1:0] exc_iaddr,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic          enq_kind,
  input  logic [DW-1:0] enq_value,
  input  logic [RW-1:0] enq_dest,
  input  logic [AW-1:0] enq_iaddr,
  input  logic          enq_force,
  output logic          overflow_err,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [RW-1:0] wr_dest,
  output logic [DW-1:0] wr_value,
  output logic [AW-1:0] vis_pc,
  output logic [AW-1:0] next_pc,
  output logic          next_pc_valid,
  output logic          commit_done,
  output logic          busy
);
  import pcq_pkg::*;

  localparam int ENT_W = 2 + AW + RW + DW;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cq_state_e st;
  logic [IW-1:0]    rd_idx;
  logic [AW-1:0]    save_pc;
  logic [AW-1:0]    new_pc;
  logic             bseen;
  logic             link_flag;
  logic             x_pend, x_fp;
  logic [SW-1:0]    x_status;
  logic [AW-1:0]    x_iaddr;

  logic [ENT_W-1:0] push_data, rd_data;
  logic [CW-1:0]    q_count;
  logic             q_full, q_clr, q_push;

  logic             e_kind, e_force;
  logic [AW-1:0]    e_iaddr;
  logic [RW-1:0]    e_dest;
  logic [DW-1:0]    e_value;
  logic             f_keep, f_take, f_emit;
  logic             adv, last;
  logic             idle;

  assign idle = (st == S_IDLE);

  // entry layout: kind, force, issuing address, dest, value
  assign push_data = {enq_kind, enq_force, enq_iaddr, enq_dest, enq_value};
  assign {e_kind, e_force, e_iaddr, e_dest, e_value} = rd_data;

  assign enq_ready    = idle && !q_full && !pkt_start && !commit_start;
  assign q_push       = enq_valid && enq_ready;
  assign overflow_err = enq_valid && idle && q_full && !pkt_start && !commit_start;
  assign q_clr        = (st == S_FIN) || (idle && pkt_start && !commit_start);

  pcq_store #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_clr),
    .push      (q_push),
    .push_data (push_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .count     (q_count),
    .full      (q_full)
  );

  pcq_filter #(
    .AW (AW),
    .SW (SW)
  ) i_filter (
    .kind        (e_kind),
    .force_wr    (e_force),
    .iaddr       (e_iaddr),
    .exc_pending (x_pend),
    .exc_fp      (x_fp),
    .exc_status  (x_status),
    .exc_iaddr   (x_iaddr),
    .branch_seen (bseen),
    .keep        (f_keep),
    .take_branch (f_take),
    .emit_data   (f_emit)
  );

  assign adv  = (st == S_DRAIN) && (!f_emit || wr_ready);
  assign last = ({1'b0, rd_idx} == (q_count - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd_idx   <= '0;
      save_pc  <= '0;
      new_pc   <= '0;
      bseen    <= 1'b0;
      x_pend   <= 1'b0;
      x_fp     <= 1'b0;
      x_status <= '0;
      x_iaddr  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (commit_start) begin
            save_pc  <= cur_pc;
            new_pc   <= cur_pc;
            bseen    <= 1'b0;
            rd_idx   <= '0;
            x_pend   <= exc_pending;
            x_fp     <= exc_fp;
            x_status <= exc_status;
            x_iaddr  <= exc_iaddr;
            if (q_count != '0)  st <= S_DRAIN;
            else if (link_flag) st <= S_LINK;
            else                st <= S_FIN;
          end
        end
        S_DRAIN: begin
          if (adv) begin
            if (f_take) begin
              new_pc <= AW'(e_value);
              bseen  <= 1'b1;
            end
            if (last) st <= link_flag ? S_LINK : S_FIN;
            else      rd_idx <= rd_idx + IW'(1);
          end
        end
        S_LINK: begin
          if (wr_ready) st <= S_FIN;
        end
        S_FIN: begin
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_flag <= 1'b0;
    end else if (st == S_LINK && wr_ready) begin
      link_flag <= 1'b0;
    end else if (link_set) begin
      link_flag <= 1'b1;
    end
  end

  assign wr_valid      = ((st == S_DRAIN) && f_emit) || (st == S_LINK);
  assign wr_dest       = (st == S_LINK) ? LINK_DEST : e_dest;
  assign wr_value      = (st == S_LINK) ? DW'(save_pc) : e_value;
  assign vis_pc        = (st == S_DRAIN) ? e_iaddr : new_pc;
  assign next_pc       = new_pc;
  assign next_pc_valid = (st == S_FIN);
  assign commit_done   = (st == S_FIN);
  assign busy          = !idle;

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_dest) && $stable(wr_value)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done);

  // R9
  clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (q_count == '0));

  // R10
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> (q_count == CW'(DEPTH)));

  // R2
  branch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bseen && (st == S_DRAIN)) |=> $stable(new_pc));

  // R8
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LINK && wr_ready && !link_set) |=> !link_flag);

endmodule

// File: tb/test_pcq_top.sv
module test_pcq_top;

  localparam int DW = 32;
  localparam int AW = 32;
  localparam int RW = 5;
  localparam int SW = 6;
  localparam int DEPTH = 8;
  localparam logic [RW-1:0] LINKD = 5'd31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_start = 1'b0;
  logic [AW-1:0] cur_pc = '0;
  logic          commit_start = 1'b0;
  logic          link_set = 1'b0;
  logic          exc_pending = 1'b0;
  logic          exc_fp = 1'b0;
  logic [SW-1:0] exc_status = '0;
  logic [AW-1:0] exc_iaddr = '0;
  logic          enq_valid = 1'b0;
  logic          enq_ready;
  logic          enq_kind = 1'b0;
  logic [DW-1:0] enq_value = '0;
  logic [RW-1:0] enq_dest = '0;
  logic [AW-1:0] enq_iaddr = '0;
  logic          enq_force = 1'b0;
  logic          overflow_err;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [RW-1:0] wr_dest;
  logic [DW-1:0] wr_value;
  logic [AW-1:0] vis_pc, next_pc;
  logic          next_pc_valid, commit_done, busy;

  always #2 clk = ~clk;

  pcq_top i_pcq_top (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .cur_pc(cur_pc),
    .commit_start(commit_start), .link_set(link_set),
    .exc_pending(exc_pending), .exc_fp(exc_fp), .exc_status(exc_status),
    .exc_iaddr(exc_iaddr), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_kind(enq_kind), .enq_value(enq_value), .enq_dest(enq_dest),
    .enq_iaddr(enq_iaddr), .enq_force(enq_force), .overflow_err(overflow_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dest(wr_dest),
    .wr_value(wr_value), .vis_pc(vis_pc), .next_pc(next_pc),
    .next_pc_valid(next_pc_valid), .commit_done(commit_done), .busy(busy)
  );

  typedef struct {
    logic          kind;
    logic          frc;
    logic [AW-1:0] ia;
    logic [RW-1:0] dest;
    logic [DW-1:0] val;
  } ent_t;

  typedef struct {
    logic [RW-1:0] dest;
    logic [DW-1:0] val;
    logic [AW-1:0] ia;
    bit            vis;
  } exp_t;

  ent_t model[$];
  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   bp_mode = 0;
  bit   link_pend = 0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write-port ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor: pops expected writes as they are accepted
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (sb.size() == 0) begin
        chk(0, "R1 unexpected write", {27'd0, wr_dest, wr_value}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(wr_dest == e.dest, "R1/R8 dest", 64'(wr_dest), 64'(e.dest));
        chk(wr_value == e.val, "R1/R8 value", 64'(wr_value), 64'(e.val));
        if (e.vis) chk(vis_pc == e.ia, "R7 vis_pc", 64'(vis_pc), 64'(e.ia));
      end
    end
  end

  // caller is at a negedge
  task automatic enq(input logic k, input logic [DW-1:0] v, input logic [RW-1:0] d,
                     input logic [AW-1:0] ia, input logic f);
    ent_t e;
    enq_valid = 1'b1; enq_kind = k; enq_value = v; enq_dest = d;
    enq_iaddr = ia; enq_force = f;
    #0;
    if (model.size() < DEPTH) begin
      e.kind = k; e.frc = f; e.ia = ia; e.dest = d; e.val = v;
      model.push_back(e);
    end else begin
      // R10: full queue refuses and flags the loss
      chk(enq_ready == 1'b0, "R10 ready low when full", 64'(enq_ready), 64'd0);
      chk(overflow_err == 1'b1, "R10 overflow_err", 64'(overflow_err), 64'd1);
    end
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic new_packet();
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    model.delete();
  endtask

  task automatic do_link();
    link_set = 1'b1;
    @(negedge clk);
    link_set = 1'b0;
    link_pend = 1;
  endtask

  task automatic commit(input logic [AW-1:0] pc, input string tag);
    bit seen = 0;
    logic [AW-1:0] npc = pc;
    int n = model.size();
    int cyc = 0;
    int lw = link_pend ? 1 : 0;
    foreach (model[i]) begin
      bit m, keep;
      m = exc_pending && (model[i].ia == exc_iaddr);
      keep = !m || (exc_fp ? ((exc_status & ~6'b000111) == 0) : model[i].frc);
      if (keep) begin
        if (model[i].kind) begin
          if (!seen) begin npc = AW'(model[i].val); seen = 1; end
        end else begin
          exp_t x;
          x.dest = model[i].dest; x.val = model[i].val; x.ia = model[i].ia; x.vis = 1;
          sb.push_back(x);
        end
      end
    end
    if (link_pend) begin
      exp_t x;
      x.dest = LINKD; x.val = DW'(pc); x.ia = '0; x.vis = 0;
      sb.push_back(x);
    end
    cur_pc = pc;
    commit_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    commit_start = 1'b0;
    cyc = 1;
    while (!commit_done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(next_pc_valid == 1'b1, {"R11 next_pc_valid ", tag}, 64'(next_pc_valid), 64'd1);
    chk(next_pc == npc, {"R2/R3 next_pc ", tag}, 64'(next_pc), 64'(npc));
    if (!bp_mode)
      chk(cyc == n + lw + 1, {"R11 done latency ", tag}, 64'(cyc), 64'(n + lw + 1));
    chk(sb.size() == 0, {"R1 all writes seen ", tag}, 64'(sb.size()), 64'd0);
    @(negedge clk);
    chk(commit_done == 1'b0, {"R11 single pulse ", tag}, 64'(commit_done), 64'd0);
    model.delete();
    link_pend = 0;
    exc_pending = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(enq_ready == 1'b1, "reset enq_ready", 64'(enq_ready), 64'd1);
    chk(wr_valid == 1'b0, "reset wr_valid", 64'(wr_valid), 64'd0);
    chk(commit_done == 1'b0 && busy == 1'b0, "reset done/busy", 64'(commit_done), 64'd0);

    // R1, R3: plain data writes, no branch
    new_packet();
    enq(0, 32'h11, 5'd1, 32'h100, 0);
    enq(0, 32'h22, 5'd2, 32'h104, 0);
    enq(0, 32'h33, 5'd3, 32'h108, 0);
    commit(32'h2000, "plain");

    // R2: two branches, first wins
    new_packet();
    enq(1, 32'h4000, 5'd0, 32'h200, 0);
    enq(0, 32'h44, 5'd4, 32'h204, 0);
    enq(1, 32'h5000, 5'd0, 32'h208, 0);
    commit(32'h3000, "two branches");

    // R4, R5: fp exception with benign status keeps matching entries
    new_packet();
    enq(0, 32'h55, 5'd5, 32'h300, 0);
    enq(0, 32'h66, 5'd6, 32'h304, 0);
    exc_pending = 1; exc_fp = 1; exc_status = 6'b000101; exc_iaddr = 32'h300;
    commit(32'h3100, "fp benign");

    // R4, R5: fp exception with invalid bit drops matching entries
    new_packet();
    enq(0, 32'h77, 5'd7, 32'h400, 0);
    enq(0, 32'h88, 5'd8, 32'h404, 1);
    enq(0, 32'h99, 5'd9, 32'h400, 1);
    exc_pending = 1; exc_fp = 1; exc_status = 6'b001001; exc_iaddr = 32'h400;
    commit(32'h3200, "fp invalid");

    // R6, R2: other exception class; unforced matching branch dropped
    new_packet();
    enq(1, 32'h6000, 5'd0, 32'h500, 0);
    enq(0, 32'haa, 5'd10, 32'h500, 1);
    enq(0, 32'hbb, 5'd11, 32'h500, 0);
    enq(1, 32'h7000, 5'd0, 32'h504, 0);
    exc_pending = 1; exc_fp = 0; exc_status = 6'b000001; exc_iaddr = 32'h500;
    commit(32'h3300, "forced");

    // R8: link write after data, then not repeated
    new_packet();
    enq(0, 32'hcc, 5'd12, 32'h600, 0);
    do_link();
    commit(32'h3400, "link");
    new_packet();
    enq(0, 32'hdd, 5'd13, 32'h700, 0);
    commit(32'h3500, "link cleared");

    // R10: overflow
    new_packet();
    for (int i = 0; i < DEPTH + 1; i++)
      enq(0, DW'(32'h1000 + i), RW'(i), AW'(32'h800 + 4 * i), 0);
    commit(32'h3600, "full");

    // R9: packet start clears the queue
    new_packet();
    enq(0, 32'hee, 5'd14, 32'h900, 0);
    enq(1, 32'h8000, 5'd0, 32'h904, 0);
    new_packet();
    commit(32'h3700, "cleared");

    // R12: back-pressure on the write port
    bp_mode = 1;
    new_packet();
    for (int i = 0; i < 6; i++)
      enq(0, DW'(32'hab00 + i), RW'(i + 1), AW'(32'ha00 + 4 * i), 0);
    do_link();
    commit(32'h3800, "backpressure");
    bp_mode = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule